// File: doc/BRIEF.md
# Posit Word Unpacker to Sign, Scale and Fraction

This block turns one tapered-precision posit word into the normal form that an arithmetic datapath consumes. The outputs are a not-a-real flag, a zero flag, a sign bit, a signed binary scale and an unsigned fraction. The hidden leading one is implied and is not stored. Each posit has a variable-length regime run. Its value is folded together with the fixed-width exponent field into a single integer power of two. The bits left over after that become the fraction, aligned to the most significant end.

The word width, the exponent field width, the scale width and the fraction width are all parameters. Elaboration checks reject any combination that cannot hold the full scale range or every explicit fraction bit. A word presented with `in_valid` high is decoded in a single pass of combinational logic. It is captured into output registers, so the result appears one clock later together with `out_valid`. When no word is presented, the registers keep their contents.

Top module: `posit_ssf_unpack`

## Requirements
- R1: `out_valid` equals the value `in_valid` had at the previous rising clock edge. A low `rst_n` at a rising edge makes `out_valid` 0 at that edge.
- R2: The input word of all zeros yields `out_zero`=1, `out_nar`=0, and `out_sign`, `out_scale` and `out_frac` all zero.
- R3: The input word with only its top bit set yields `out_nar`=1, `out_zero`=0, and `out_sign`, `out_scale` and `out_frac` all zero.
- R4: A word whose top bit is 1 (other than the R3 pattern) is negated as a whole in two's complement and then decoded. The result is the magnitude's decode with `out_sign`=1. A word whose top bit is 0 gives `out_sign`=0.
- R5: The bits below the sign open with a run of m equal bits. The run ends at the first opposite bit or at the end of the word. A run of ones gives regime k = m-1, a run of zeros gives k = -m, and `out_scale` = k·2^ES + e. Here e is the ES-bit unsigned field that follows the terminating bit, and `out_scale` is written in SCALE_W-bit two's complement.
- R6: Exponent bits that lie past the end of the word read as zero.
- R7: The bits after the exponent field fill `out_frac` from its most significant bit downward, with zeros padded on the right. The leading one is implied and is not part of `out_frac`.
- R8: The scale of every non-special word lies within ±(NBITS-2)·2^ES. The largest positive word and the smallest positive word reach the two ends exactly.
- R9: While `in_valid` is low, `out_nar`, `out_zero`, `out_sign`, `out_scale` and `out_frac` keep their values.
- R10: A low `rst_n` at a rising edge clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks `in_word` as a word to decode |
| in_word | input | NBITS | Posit word to unpack |
| out_valid | output | 1 | A decoded result is present this cycle |
| out_nar | output | 1 | Result is not-a-real |
| out_zero | output | 1 | Result is exactly zero |
| out_sign | output | 1 | Sign of the result, 1 for negative |
| out_scale | output | SCALE_W | Signed power-of-two scale |
| out_frac | output | FRAC_W | Fraction bits below the implied leading one |

## Verification
The hardest cases to reach are the regime runs that swallow the exponent field. These are words near the largest and smallest magnitudes, where the exponent is cut short by the end of the word. They are reached only by a few specific bit patterns, so the stimulus table lists them explicitly. The same is done for their two's complement negatives, which route the extremes through the negation path. Fraction alignment is exercised with runs of one and two bits, which leave the most explicit fraction bits behind. Continuous back-to-back words and a reset in the middle of a stream cover the register timing.

// File: rtl/posit_ssf_pkg.sv
package posit_ssf_pkg;

   // Largest magnitude of the combined scale for a word/exponent pair.
   function automatic int scale_limit(int pw, int ew);
      return (pw - 2) << ew;
   endfunction

   // Explicit fraction bits that survive the shortest (two-bit) regime.
   function automatic int max_frac_bits(int pw, int ew);
      return pw - 3 - ew;
   endfunction

   // Width of the run-length counter; must represent pw-1.
   function automatic int run_bits(int pw);
      return $clog2(pw);
   endfunction

   // Width of the signed regime value; must hold +/-(pw-1).
   function automatic int regime_bits(int pw);
      return $clog2(pw) + 2;
   endfunction

endpackage

// File: rtl/posit_sign_strip.sv
module posit_sign_strip #(
   parameter int PW = 8
) (
   input  logic [PW-1:0] word,
   output logic [PW-2:0] body,
   output logic          sign,
   output logic          is_zero,
   output logic          is_nar
);

   localparam int BW = PW - 1;

   logic          top;
   logic [BW-1:0] low;
   logic [BW-1:0] low_neg;

   assign top     = word[PW-1];
   assign low     = word[BW-1:0];
   assign low_neg = ~low + BW'(1);

   // The low bits of a full-word negation equal the negation of the low bits.
   assign body    = top ? low_neg : low;
   assign is_zero = (top == 1'b0) && (low == '0);
   assign is_nar  = (top == 1'b1) && (low == '0);
   assign sign    = top & ~is_nar;

endmodule

// File: rtl/posit_regime_scan.sv
module posit_regime_scan
   import posit_ssf_pkg::*;
#(
   parameter int PW = 8
) (
   input  logic [PW-2:0]                 body,
   output logic signed [regime_bits(PW)-1:0] regime,
   output logic [run_bits(PW)-1:0]       consumed
);

   localparam int BW = PW - 1;
   localparam int RW = run_bits(PW);
   localparam int KW = regime_bits(PW);

   logic          lead;
   logic [BW-1:0] same;
   logic [RW-1:0] run_len;
   logic signed [KW-1:0] run_s;

   assign lead = body[BW-1];

   // same[j] is set while the first j+1 bits all match the leading bit.
   genvar j;
   generate
      for (j = 0; j < BW; j++) begin : g_chain
         if (j == 0) begin : g_first
            assign same[j] = 1'b1;
         end else begin : g_next
            assign same[j] = same[j-1] & (body[BW-1-j] == lead);
         end
      end
   endgenerate

   always_comb begin
      run_len = '0;
      for (int i = 0; i < BW; i++) begin
         run_len = run_len + RW'(same[i]);
      end
   end

   assign run_s    = $signed(KW'(run_len));
   assign regime   = lead ? (run_s - $signed(KW'(1))) : (-run_s);
   assign consumed = (run_len == RW'(BW)) ? RW'(BW) : (run_len + RW'(1));

endmodule

// File: rtl/posit_field_align.sv
module posit_field_align
   import posit_ssf_pkg::*;
#(
   parameter int PW      = 8,
   parameter int EW      = 1,
   parameter int SCALE_W = 6,
   parameter int FRAC_W  = 4
) (
   input  logic [PW-2:0]                     body,
   input  logic [run_bits(PW)-1:0]           consumed,
   input  logic signed [regime_bits(PW)-1:0] regime,
   output logic [SCALE_W-1:0]                scale,
   output logic [FRAC_W-1:0]                 frac
);

   localparam int BW = PW - 1;
   localparam int QW = BW - 2;                 // bits beyond the minimum regime
   localparam int FW = max_frac_bits(PW, EW);  // explicit fraction bits at most
   localparam int RW = run_bits(PW);

   // At least two regime bits are always used, so the top two body bits
   // never reach the exponent or fraction: shift only the rest.
   logic [QW-1:0] rest;
   logic [FW-1:0] tail;

   assign rest = body[QW-1:0] << (consumed - RW'(2));

   generate
      if (EW == 0) begin : g_no_exp
         assign tail  = rest;
         assign scale = SCALE_W'(int'(regime));
      end else begin : g_exp
         logic [EW-1:0] expo;
         // Cut-off exponent bits are zeros shifted in from the right.
         assign expo  = rest[QW-1 -: EW];
         assign tail  = rest[FW-1:0];
         assign scale = SCALE_W'((int'(regime) * (1 << EW)) + int'(expo));
      end

      if (FRAC_W == FW) begin : g_frac_exact
         assign frac = tail;
      end else begin : g_frac_pad
         assign frac = {tail, {(FRAC_W - FW){1'b0}}};
      end
   endgenerate

endmodule

// File: rtl/posit_ssf_unpack.sv
module posit_ssf_unpack
   import posit_ssf_pkg::*;
#(
   parameter int PW      = 8,
   parameter int EW      = 1,
   parameter int SCALE_W = 6,
   parameter int FRAC_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [PW-1:0]      in_word,
   output logic               out_valid,
   output logic               out_nar,
   output logic               out_zero,
   output logic               out_sign,
   output logic [SCALE_W-1:0] out_scale,
   output logic [FRAC_W-1:0]  out_frac
);

   localparam int KW    = regime_bits(PW);
   localparam int RW    = run_bits(PW);
   localparam int LIMIT = scale_limit(PW, EW);

   generate
      if (PW < EW + 4) begin : g_bad_width
         $error("word width leaves no fraction bit for this exponent width");
      end
      if (FRAC_W < max_frac_bits(PW, EW)) begin : g_bad_frac
         $error("fraction width cannot hold every explicit fraction bit");
      end
      if ((1 << (SCALE_W - 1)) <= LIMIT) begin : g_bad_scale
         $error("scale width cannot hold the full scale range");
      end
   endgenerate

   logic [PW-2:0]        body;
   logic                 sign_c;
   logic                 zero_c;
   logic                 nar_c;
   logic signed [KW-1:0] regime;
   logic [RW-1:0]        consumed;
   logic [SCALE_W-1:0]   scale_c;
   logic [FRAC_W-1:0]    frac_c;
   logic                 special;

   posit_sign_strip #(.PW(PW)) u_strip (
      .word    (in_word),
      .body    (body),
      .sign    (sign_c),
      .is_zero (zero_c),
      .is_nar  (nar_c)
   );

   posit_regime_scan #(.PW(PW)) u_scan (
      .body     (body),
      .regime   (regime),
      .consumed (consumed)
   );

   posit_field_align #(
      .PW      (PW),
      .EW      (EW),
      .SCALE_W (SCALE_W),
      .FRAC_W  (FRAC_W)
   ) u_align (
      .body     (body),
      .consumed (consumed),
      .regime   (regime),
      .scale    (scale_c),
      .frac     (frac_c)
   );

   assign special = zero_c | nar_c;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_nar   <= 1'b0;
         out_zero  <= 1'b0;
         out_sign  <= 1'b0;
         out_scale <= '0;
         out_frac  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_nar   <= nar_c;
            out_zero  <= zero_c;
            out_sign  <= sign_c;
            out_scale <= special ? '0 : scale_c;
            out_frac  <= special ? '0 : frac_c;
         end
      end
   end

endmodule

// File: rtl/posit_ssf_unpack_chk.sv
module posit_ssf_unpack_chk #(
   parameter int PW      = 8,
   parameter int EW      = 1,
   parameter int SCALE_W = 6,
   parameter int FRAC_W  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [PW-1:0]      in_word,
   input logic               out_valid,
   input logic               out_nar,
   input logic               out_zero,
   input logic               out_sign,
   input logic [SCALE_W-1:0] out_scale,
   input logic [FRAC_W-1:0]  out_frac
);

   localparam int LIMIT = (PW - 2) << EW;
   localparam logic [PW-1:0] NAR_WORD = {1'b1, {(PW-1){1'b0}}};

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_zero_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_word == '0) |=> (out_zero && !out_nar));

   assert_nar_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_word == NAR_WORD) |=> (out_nar && !out_zero));

   // R2 and R3: special results carry no sign, scale or fraction
   assert_special_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_nar || out_zero)) |-> (!out_sign && out_scale == '0 && out_frac == '0));

   assert_negative_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_word[PW-1] && in_word[PW-2:0] != '0) |=> (out_sign && !out_nar && !out_zero));

   assert_positive_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_word[PW-1]) |=> !out_sign);

   assert_scale_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (($signed(out_scale) <= LIMIT) && ($signed(out_scale) >= -LIMIT)));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_scale) && $stable(out_frac) && $stable(out_sign)
                     && $stable(out_nar) && $stable(out_zero)));

endmodule

bind posit_ssf_unpack posit_ssf_unpack_chk #(
   .PW      (PW),
   .EW      (EW),
   .SCALE_W (SCALE_W),
   .FRAC_W  (FRAC_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_word   (in_word),
   .out_valid (out_valid),
   .out_nar   (out_nar),
   .out_zero  (out_zero),
   .out_sign  (out_sign),
   .out_scale (out_scale),
   .out_frac  (out_frac)
);

// File: tb/test_posit_ssf_unpack.sv
`timescale 1ns/1ps
module test_posit_ssf_unpack;

   localparam int PW = 8;
   localparam int EW = 1;
   localparam int SW = 6;
   localparam int FW = 4;
   localparam int NV = 21;

   // entry: {req 4, word 8, nar 1, zero 1, sign 1, scale 6, frac 4}
   localparam logic [24:0] VEC [NV] = '{
      {4'd5, 8'h40, 3'b000, 6'h00, 4'h0},  // R5  k=0 e=0 -> 1.0
      {4'd7, 8'h48, 3'b000, 6'h00, 4'h8},  // R7  fraction 1000
      {4'd5, 8'h50, 3'b000, 6'h01, 4'h0},  // R5  exponent 1
      {4'd8, 8'h7F, 3'b000, 6'h0C, 4'h0},  // R8  largest, +12
      {4'd8, 8'h01, 3'b000, 6'h34, 4'h0},  // R8  smallest, -12
      {4'd5, 8'h60, 3'b000, 6'h02, 4'h0},  // R5  run of two ones
      {4'd5, 8'h6C, 3'b000, 6'h03, 4'h8},  // R5  k=1 e=1
      {4'd5, 8'h30, 3'b000, 6'h3F, 4'h0},  // R5  run of one zero, -1
      {4'd7, 8'h27, 3'b000, 6'h3E, 4'h7},  // R7  fraction 0111, -2
      {4'd4, 8'hC0, 3'b001, 6'h00, 4'h0},  // R4  -1.0
      {4'd4, 8'hB8, 3'b001, 6'h00, 4'h8},  // R4  -1.5
      {4'd4, 8'h81, 3'b001, 6'h0C, 4'h0},  // R4  negated largest
      {4'd4, 8'hFF, 3'b001, 6'h34, 4'h0},  // R4  negated smallest
      {4'd2, 8'h00, 3'b010, 6'h00, 4'h0},  // R2  zero
      {4'd3, 8'h80, 3'b100, 6'h00, 4'h0},  // R3  not-a-real
      {4'd6, 8'h7E, 3'b000, 6'h0A, 4'h0},  // R6  exponent cut off, +10
      {4'd6, 8'h7D, 3'b000, 6'h09, 4'h0},  // R6  exponent just fits, +9
      {4'd5, 8'h02, 3'b000, 6'h36, 4'h0},  // R5  -10
      {4'd5, 8'h03, 3'b000, 6'h37, 4'h0},  // R5  -9
      {4'd7, 8'h4F, 3'b000, 6'h00, 4'hF},  // R7  all fraction ones
      {4'd4, 8'h91, 3'b001, 6'h03, 4'hE}   // R4  negative with fraction
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [PW-1:0] in_word = '0;
   logic          out_valid, out_nar, out_zero, out_sign;
   logic [SW-1:0] out_scale;
   logic [FW-1:0] out_frac;

   int n_checks = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   posit_ssf_unpack #(.PW(PW), .EW(EW), .SCALE_W(SW), .FRAC_W(FW)) i_posit_ssf_unpack (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_word   (in_word),
      .out_valid (out_valid),
      .out_nar   (out_nar),
      .out_zero  (out_zero),
      .out_sign  (out_sign),
      .out_scale (out_scale),
      .out_frac  (out_frac)
   );

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic check_vec(input int i);
      logic [24:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d word %02h", v[24:21], v[20:13]);
      check({tag, " valid"}, 32'(out_valid), 32'd1);
      check({tag, " nar"},   32'(out_nar),   32'(v[12]));
      check({tag, " zero"},  32'(out_zero),  32'(v[11]));
      check({tag, " sign"},  32'(out_sign),  32'(v[10]));
      check({tag, " scale"}, 32'(out_scale), 32'(v[9:4]));
      check({tag, " frac"},  32'(out_frac),  32'(v[3:0]));
   endtask

   task automatic run_all;
      // R10 / R1: reset state
      repeat (3) @(negedge clk);
      check("R10 reset valid", 32'(out_valid), 32'd0);
      check("R10 reset scale", 32'(out_scale), 32'd0);
      check("R10 reset flags", 32'({out_nar, out_zero, out_sign}), 32'd0);
      rst_n = 1'b1;

      // table walk, one word per cycle with in_valid held high (R1)
      in_valid = 1'b1;
      in_word  = VEC[0][20:13];
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         check_vec(i);
         if (i + 1 < NV) in_word = VEC[i+1][20:13];
      end

      // R9: idle cycles leave the last result (word 91) untouched
      in_valid = 1'b0;
      in_word  = 8'h7F;
      @(negedge clk);
      check("R1 valid drops", 32'(out_valid), 32'd0);
      @(negedge clk);
      check("R9 hold scale", 32'(out_scale), 32'h03);
      check("R9 hold frac",  32'(out_frac),  32'hE);
      check("R9 hold sign",  32'(out_sign),  32'd1);

      // R1: single word after an idle gap
      in_valid = 1'b1;
      in_word  = 8'h50;
      @(negedge clk);
      check("R1 gap valid", 32'(out_valid), 32'd1);
      check("R5 gap scale", 32'(out_scale), 32'h01);
      in_word = 8'h80;
      @(negedge clk);
      check("R3 nar after word", 32'(out_nar), 32'd1);
      check("R3 nar scale", 32'(out_scale), 32'd0);

      // R10: reset in the middle of a stream
      in_word = 8'h7F;
      rst_n   = 1'b0;
      @(negedge clk);
      check("R10 mid valid", 32'(out_valid), 32'd0);
      check("R10 mid scale", 32'(out_scale), 32'd0);
      check("R10 mid nar",   32'(out_nar),   32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 after reset scale", 32'(out_scale), 32'h0C);
      in_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule